// File: doc/BRIEF.md
# Burst-Counted SPI Master

This block is a register-driven SPI master for short flash-style reads and writes. Software fills a byte transmit queue and sets two counts. The first is the total number of bytes to clock on the bus. The second is how many of those bytes come from the transmit queue. Software then sets an exchange bit. The block pulls chip select low and clocks exactly the total count of bytes, most significant bit first, in SPI mode 0. Every byte it receives goes into a receive queue.

A typical use is a memory read. Software queues a command byte and three address bytes and sets the transmit count to four. It sets the total count to four plus the number of data bytes wanted. It then polls the receive level until every byte has arrived, and pops the bytes. Once the transmit count is used up, the block drives zero bytes. The bus clock is a fixed division of the module clock, chosen by a clock configuration register.

Top module: `spi_burst_master`

Register offsets, all 32-bit:
- 0x00 control: bit 0 enable, bit 1 master, bit 8 exchange, bit 31 soft reset.
- 0x04 clock configuration.
- 0x08 total count.
- 0x0C transmit count.
- 0x10 status.
- 0x14 transmit data; a write pushes bits 7:0.
- 0x18 receive data; a read pops one byte.

## Requirements
- R1: After reset, chip select is high and the bus clock and data out are low. Control, counts and status read 0, and the clock configuration reads 0x00001000.
- R2: A control write with bits 0, 1 and 8 all set starts a burst when the total count is nonzero, and pulls chip select low on the next edge. Bit 8 reads 1 until chip select rises, then reads 0. If enable or master is 0 in the same write, the write starts nothing.
- R3: A burst gives exactly 8 × total-count rising bus clock edges. Chip select stays low for the whole burst and rises with the last falling edge. The bus clock is low whenever chip select is high.
- R4: Data is sent most significant bit first in mode 0. The output changes only while the bus clock is low, and the input is sampled on each rising edge.
- R5: The first transmit-count bytes of a burst are taken from the transmit queue in order. All later bytes are sent as 0x00. A byte due from an empty transmit queue is also sent as 0x00.
- R6: Every byte received is appended to the receive queue in order. A read at 0x18 returns and removes the oldest byte. A read of an empty queue returns 0 and changes nothing.
- R7: Status bits 7:0 give the receive queue level (0 to 64), and bits 15:8 give the transmit queue level. A push to a full transmit queue is dropped.
- R8: A byte that arrives while the receive queue is full is dropped and sets status bit 16. Bit 16 stays set until a soft reset.
- R9: Writing control bit 31 empties both queues, clears bit 16 and ends any burst with chip select high. Bit 31 reads 1 for one cycle and then 0. Enable and master keep their written values.
- R10: Clock configuration with bit 12 set gives a bus clock period of 2 × (N + 1) module clocks, where N is bits 7:0. With bit 12 clear, the period is 2^(M + 1) clocks, where M is bits 3:0. So 0x1000 divides by 2 and 0x1001 divides by 4.
- R11: A receive push and a receive pop in the same cycle leave the level unchanged and lose no byte. This also holds when the queue is full.
- R12: The total-count and transmit-count registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on receive data) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_sclk | output | 1 | Bus clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data in |

## Verification
Two functions can fall in the same cycle: a software pop of the receive queue and the engine's push of a finished byte. The bench provokes this during a 20-byte burst at the fastest clock setting. It pops once every 17 cycles while a byte lands every 16, so the pop phase sweeps over every push cycle. The run is judged by the byte order and by the popped count plus the final level equalling the total count. A bound property checks that the level holds still in each cycle where the two coincide.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

   // register byte offsets
   localparam logic [7:0] OFS_CTRL  = 8'h00;
   localparam logic [7:0] OFS_CLK   = 8'h04;
   localparam logic [7:0] OFS_TOTAL = 8'h08;
   localparam logic [7:0] OFS_TXCNT = 8'h0C;
   localparam logic [7:0] OFS_STAT  = 8'h10;
   localparam logic [7:0] OFS_TXD   = 8'h14;
   localparam logic [7:0] OFS_RXD   = 8'h18;

   // control bit positions
   localparam int unsigned BIT_EN   = 0;
   localparam int unsigned BIT_MST  = 1;
   localparam int unsigned BIT_XCH  = 8;
   localparam int unsigned BIT_SRST = 31;

   // clock configuration: linear divider select bit
   localparam int unsigned BIT_LIN  = 12;
   localparam logic [31:0] CLK_CFG_RST = 32'h0000_1000;

   typedef struct packed {
      logic mst;
      logic en;
   } ctrl_t;

endpackage

// File: rtl/spi_burst_fifo.sv
module spi_burst_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 64,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("spi_burst_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_nx, rp_nx;
   logic [LVL_W-1:0] cnt;
   logic             do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == LVL_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dout    = mem[rp];
   assign level   = cnt;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap
      assign wp_nx = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/spi_burst_clkgen.sv
module spi_burst_clkgen #(
   parameter int unsigned HALF_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [HALF_W-1:0] half,
   output logic              tick
);

   if (HALF_W < 9) begin : g_bad_half
      $error("spi_burst_clkgen: HALF_W must hold a half period of 256");
   end

   logic [HALF_W-1:0] cnt;

   // half is never zero: the decoder adds one or shifts a one
   assign tick = run && (cnt >= half - HALF_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  logic [CNT_W-1:0] total_len,
   input  logic [CNT_W-1:0] tx_len,
   input  logic             tick,
   input  logic [7:0]       tx_head,
   input  logic             tx_empty,
   input  logic             miso,
   output logic             tx_pop,
   output logic             rx_push,
   output logic [7:0]       rx_byte,
   output logic             busy,
   output logic             sclk,
   output logic             mosi,
   output logic             cs_n
);

   logic             busy_q, sclk_q;
   logic [2:0]       bit_q;
   logic [CNT_W-1:0] left_q, txleft_q, src_left;
   logic [7:0]       sh_tx, sh_rx, load_byte;
   logic             adv, last_bit, done, load, take;

   assign adv       = busy_q && tick && !clr;
   assign last_bit  = adv && sclk_q && (bit_q == 3'd7);
   assign done      = last_bit && (left_q == CNT_W'(1));
   assign load      = start || (last_bit && !done);
   assign src_left  = start ? tx_len : txleft_q;
   assign take      = load && (src_left != '0);
   assign tx_pop    = take && !tx_empty;
   assign load_byte = tx_pop ? tx_head : 8'h00;

   assign rx_push = last_bit;
   assign rx_byte = sh_rx;
   assign busy    = busy_q;
   assign sclk    = sclk_q;
   assign mosi    = busy_q && sh_tx[7];
   assign cs_n    = !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         sclk_q   <= 1'b0;
         bit_q    <= '0;
         left_q   <= '0;
         txleft_q <= '0;
         sh_tx    <= '0;
         sh_rx    <= '0;
      end else if (clr) begin
         busy_q   <= 1'b0;
         sclk_q   <= 1'b0;
         bit_q    <= '0;
         left_q   <= '0;
         txleft_q <= '0;
         sh_tx    <= '0;
         sh_rx    <= '0;
      end else begin
         if (load) begin
            sh_tx    <= load_byte;
            txleft_q <= take ? src_left - 1'b1 : '0;
         end
         if (start) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            bit_q  <= '0;
            left_q <= total_len;
         end else if (adv) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               sh_rx  <= {sh_rx[6:0], miso};
            end else begin
               sclk_q <= 1'b0;
               if (bit_q == 3'd7) begin
                  bit_q <= '0;
                  if (done) busy_q <= 1'b0;
                  else      left_q <= left_q - 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  sh_tx <= {sh_tx[6:0], 1'b0};
               end
            end
         end
      end
   end

endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
   import spi_burst_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 64,
   parameter int unsigned CNT_W      = 16,
   localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1),
   localparam int unsigned HALF_W    = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [7:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        spi_sclk,
   output logic        spi_mosi,
   output logic        spi_cs_n,
   input  logic        spi_miso
);

   if (LVL_W > 8) begin : g_bad_depth
      $error("spi_burst_master: FIFO_DEPTH level must fit in 8 status bits");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("spi_burst_master: CNT_W must be 1 to 32");
   end

   ctrl_t             ctrl_q;
   logic              srst_q;
   logic [31:0]       clk_cfg_q;
   logic [CNT_W-1:0]  total_q, txcnt_q;
   logic              ovf_q;
   logic [HALF_W-1:0] half_q;

   logic              wr_ctrl, start, busy, tick;
   logic              tx_push, tx_pop, tx_full, tx_empty;
   logic [7:0]        tx_head;
   logic [LVL_W-1:0]  tx_lvl, rx_lvl;
   logic              rx_push, rx_pop_req, rx_full, rx_empty;
   logic [7:0]        rx_byte, rx_head;

   assign wr_ctrl    = reg_wr && (reg_addr == OFS_CTRL);
   assign start      = wr_ctrl && reg_wdata[BIT_XCH] && reg_wdata[BIT_EN] &&
                       reg_wdata[BIT_MST] && !reg_wdata[BIT_SRST] &&
                       !busy && !srst_q && (total_q != '0);
   assign tx_push    = reg_wr && (reg_addr == OFS_TXD);
   assign rx_pop_req = reg_rd && (reg_addr == OFS_RXD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         srst_q    <= 1'b0;
         clk_cfg_q <= CLK_CFG_RST;
         total_q   <= '0;
         txcnt_q   <= '0;
         ovf_q     <= 1'b0;
         half_q    <= HALF_W'(1);
      end else begin
         srst_q <= wr_ctrl && reg_wdata[BIT_SRST];
         if (wr_ctrl) begin
            ctrl_q.en  <= reg_wdata[BIT_EN];
            ctrl_q.mst <= reg_wdata[BIT_MST];
         end
         if (reg_wr && reg_addr == OFS_CLK)   clk_cfg_q <= reg_wdata;
         if (reg_wr && reg_addr == OFS_TOTAL) total_q   <= reg_wdata[CNT_W-1:0];
         if (reg_wr && reg_addr == OFS_TXCNT) txcnt_q   <= reg_wdata[CNT_W-1:0];
         if (start) begin
            half_q <= clk_cfg_q[BIT_LIN] ? {8'd0, clk_cfg_q[7:0]} + HALF_W'(1)
                                         : HALF_W'(1) << clk_cfg_q[3:0];
         end
         if (srst_q)
            ovf_q <= 1'b0;
         else if (rx_push && rx_full && !rx_pop_req)
            ovf_q <= 1'b1;
      end
   end

   spi_burst_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (srst_q),
      .push  (tx_push),
      .din   (reg_wdata[7:0]),
      .pop   (tx_pop),
      .dout  (tx_head),
      .level (tx_lvl),
      .full  (tx_full),
      .empty (tx_empty)
   );

   spi_burst_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (srst_q),
      .push  (rx_push),
      .din   (rx_byte),
      .pop   (rx_pop_req),
      .dout  (rx_head),
      .level (rx_lvl),
      .full  (rx_full),
      .empty (rx_empty)
   );

   spi_burst_clkgen #(.HALF_W(HALF_W)) u_clkgen (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .half  (half_q),
      .tick  (tick)
   );

   spi_burst_shifter #(.CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (srst_q),
      .start     (start),
      .total_len (total_q),
      .tx_len    (txcnt_q),
      .tick      (tick),
      .tx_head   (tx_head),
      .tx_empty  (tx_empty),
      .miso      (spi_miso),
      .tx_pop    (tx_pop),
      .rx_push   (rx_push),
      .rx_byte   (rx_byte),
      .busy      (busy),
      .sclk      (spi_sclk),
      .mosi      (spi_mosi),
      .cs_n      (spi_cs_n)
   );

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_CTRL:  reg_rdata = {srst_q, 22'd0, busy, 6'd0, ctrl_q.mst, ctrl_q.en};
         OFS_CLK:   reg_rdata = clk_cfg_q;
         OFS_TOTAL: reg_rdata = 32'(total_q);
         OFS_TXCNT: reg_rdata = 32'(txcnt_q);
         OFS_STAT:  reg_rdata = {15'd0, ovf_q, 8'(tx_lvl), 8'(rx_lvl)};
         OFS_RXD:   reg_rdata = {24'd0, rx_empty ? 8'h00 : rx_head};
         default:   reg_rdata = '0;
      endcase
   end

   // tx_full only gates pushes inside the queue; kept visible for the checker
   logic unused_ok;
   assign unused_ok = tx_full;

endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned LVL_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             sclk,
   input logic             start,
   input logic             srst,
   input logic             rx_push,
   input logic             rx_pop,
   input logic             rx_full,
   input logic [LVL_W-1:0] rx_lvl,
   input logic [LVL_W-1:0] tx_lvl,
   input logic             tx_full,
   input logic             ovf
);

   // R3: bus clock idles low while deselected
   a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R2: an accepted exchange selects the device on the next edge
   a_r2_start_selects: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !cs_n);

   // R9: soft reset ends the burst and empties both queues
   a_r9_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (cs_n && rx_lvl == '0 && tx_lvl == '0 && !ovf));

   // R8: overflow flag is sticky until soft reset
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !srst) |=> ovf);

   // R8: a byte arriving at a full queue with no pop raises the flag
   a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_full && !rx_pop && !srst) |=> ovf);

   // R11: simultaneous push and accepted pop keep the level
   a_r11_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && rx_pop && rx_lvl != '0 && !srst) |=> $stable(rx_lvl));

   // R7: levels never exceed the depth, full matches the depth
   a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_lvl <= LVL_W'(DEPTH)) && (tx_lvl <= LVL_W'(DEPTH)) &&
      (tx_full == (tx_lvl == LVL_W'(DEPTH))));

endmodule

bind spi_burst_master spi_burst_master_chk #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (spi_cs_n),
   .sclk    (spi_sclk),
   .start   (start),
   .srst    (srst_q),
   .rx_push (rx_push),
   .rx_pop  (rx_pop_req),
   .rx_full (rx_full),
   .rx_lvl  (rx_lvl),
   .tx_lvl  (tx_lvl),
   .tx_full (tx_full),
   .ovf     (ovf_q)
);

// File: tb/spi_burst_master_bench.sv
module spi_burst_master_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CTRL = 8'h00, A_CLK = 8'h04, A_TOTAL = 8'h08,
                          A_TXCNT = 8'h0C, A_STAT = 8'h10, A_TXD = 8'h14, A_RXD = 8'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_sclk, spi_mosi, spi_cs_n;
   logic        spi_miso = 1'b0;

   int checks = 0;
   int errors = 0;
   bit live = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spi_burst_master u_spi_burst_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .spi_sclk  (spi_sclk),
      .spi_mosi  (spi_mosi),
      .spi_cs_n  (spi_cs_n),
      .spi_miso  (spi_miso)
   );

   // ---------------- reference slave model ----------------
   logic [7:0] miso_q[$];
   logic [7:0] mosi_got[$];
   logic [7:0] cur_miso;
   logic [7:0] acc;
   int         mbit, abit, rises;
   time        t_prev, t_last;

   function automatic logic [7:0] next_miso();
      if (miso_q.size() > 0) return miso_q.pop_front();
      return 8'h00;
   endfunction

   always @(negedge spi_cs_n) begin
      mbit = 0;
      abit = 0;
      cur_miso = next_miso();
      spi_miso = cur_miso[7];
   end

   always @(posedge spi_cs_n) abit = 0;

   always @(posedge spi_sclk) begin
      rises++;
      t_prev = t_last;
      t_last = $time;
      acc = {acc[6:0], spi_mosi};
      abit++;
      if (abit == 8) begin
         mosi_got.push_back(acc);
         abit = 0;
      end
   end

   always @(negedge spi_sclk) begin
      if (!spi_cs_n) begin
         mbit++;
         if (mbit == 8) begin
            mbit = 0;
            cur_miso = next_miso();
         end
         spi_miso = cur_miso[3'(7 - mbit)];
      end
   end

   // every clock: R3 deselected bus clock idles low, R4 data idle when deselected
   always @(negedge clk) begin
      if (live && rst_n) begin
         checks++;
         if (spi_cs_n && (spi_sclk || spi_mosi)) begin
            errors++;
            $display("FAIL R3 idle bus: sclk=%0b mosi=%0b expected 0 0 at %0t",
                     spi_sclk, spi_mosi, $time);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      for (int n = 0; n < 20000 && !spi_cs_n; n++) @(negedge clk);
   endtask

   task automatic start_burst(input int total, input int txc);
      wr(A_TOTAL, 32'(total));
      wr(A_TXCNT, 32'(txc));
      mosi_got.delete();
      rises = 0;
      wr(A_CTRL, 32'h0000_0103);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      report();
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] d;
      logic [7:0]  exp_rx[$];
      logic [7:0]  got[$];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      live = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cs_n", 32'(spi_cs_n), 1);
      chk("R1 sclk", 32'(spi_sclk), 0);
      chk("R1 mosi", 32'(spi_mosi), 0);
      rd(A_CTRL, d);  chk("R1 ctrl", d, 0);
      rd(A_STAT, d);  chk("R1 status", d, 0);
      rd(A_TOTAL, d); chk("R1 total", d, 0);
      rd(A_CLK, d);   chk("R1 clkcfg", d, 32'h1000);

      // R12 counter readback
      wr(A_TOTAL, 32'h0000_1234); rd(A_TOTAL, d); chk("R12 total", d, 32'h1234);
      wr(A_TXCNT, 32'h0000_00AB); rd(A_TXCNT, d); chk("R12 txcnt", d, 32'hAB);

      // R2 exchange without master bit is ignored
      wr(A_TOTAL, 2);
      wr(A_CTRL, 32'h0000_0101);
      repeat (40) @(negedge clk);
      chk("R2 no start cs_n", 32'(spi_cs_n), 1);
      rd(A_CTRL, d); chk("R2 no start ctrl", d, 32'h1);

      // Burst A: command header then data, default divide by 2
      wr(A_TXD, 8'h03); wr(A_TXD, 8'h12); wr(A_TXD, 8'h34); wr(A_TXD, 8'h56);
      exp_rx.delete();
      for (int i = 0; i < 8; i++) begin
         miso_q.push_back(8'hA0 + 8'(i * 5));
         exp_rx.push_back(8'hA0 + 8'(i * 5));
      end
      start_burst(8, 4);
      chk("R2 start cs low", 32'(spi_cs_n), 0);
      rd(A_CTRL, d); chk("R2 xch busy readback", d, 32'h103);
      wait_idle();
      rd(A_CTRL, d); chk("R2 xch cleared", d, 32'h3);
      chk("R3 rising edges", 32'(rises), 64);
      chk("R10 period div2", 32'((t_last - t_prev) / CLK_PERIOD), 2);
      chk("R5 mosi count", 32'(mosi_got.size()), 8);
      for (int i = 0; i < 8; i++) begin
         logic [7:0] e;
         e = (i == 0) ? 8'h03 : (i == 1) ? 8'h12 : (i == 2) ? 8'h34 : (i == 3) ? 8'h56 : 8'h00;
         chk($sformatf("R5 R4 mosi byte %0d", i), 32'(mosi_got[i]), 32'(e));
      end
      rd(A_STAT, d); chk("R7 rx level 8", d, 32'h8);
      for (int i = 0; i < 8; i++) begin
         rd(A_RXD, d); chk($sformatf("R6 rx byte %0d", i), d, 32'(exp_rx[i]));
      end
      rd(A_RXD, d);  chk("R6 empty read", d, 0);
      rd(A_STAT, d); chk("R6 empty read level", d, 0);

      // R10 dividers
      wr(A_CLK, 32'h1001); start_burst(1, 0); wait_idle();
      chk("R10 period 0x1001", 32'((t_last - t_prev) / CLK_PERIOD), 4);
      wr(A_CLK, 32'h1004); start_burst(1, 0); wait_idle();
      chk("R10 period 0x1004", 32'((t_last - t_prev) / CLK_PERIOD), 10);
      wr(A_CLK, 32'h0002); start_burst(1, 0); wait_idle();
      chk("R10 period 0x0002", 32'((t_last - t_prev) / CLK_PERIOD), 8);
      chk("R3 one byte edges", 32'(rises), 8);
      wr(A_CTRL, 32'h8000_0003);
      wr(A_CLK, 32'h1000);

      // R5 transmit count larger than queued data
      wr(A_TXD, 8'hC5);
      start_burst(4, 3); wait_idle();
      chk("R5 underrun byte0", 32'(mosi_got[0]), 32'hC5);
      chk("R5 underrun byte1", 32'(mosi_got[1]), 0);
      chk("R5 tail byte3", 32'(mosi_got[3]), 0);
      wr(A_CTRL, 32'h8000_0003);

      // R8 receive overflow
      miso_q.delete();
      for (int i = 0; i < 66; i++) miso_q.push_back(8'(i + 1));
      start_burst(66, 0); wait_idle();
      rd(A_STAT, d); chk("R8 overflow status", d, 32'h0001_0040);
      for (int i = 0; i < 64; i++) begin
         rd(A_RXD, d);
         if (i == 0 || i == 63) chk($sformatf("R8 kept byte %0d", i), d, 32'(i + 1));
      end
      rd(A_STAT, d); chk("R8 flag sticky", d, 32'h0001_0000);
      wr(A_CTRL, 32'h8000_0003);
      rd(A_STAT, d); chk("R9 flag cleared", d, 0);

      // R11 pops sweeping across pushes
      miso_q.delete();
      exp_rx.delete();
      got.delete();
      for (int i = 0; i < 20; i++) begin
         miso_q.push_back(8'(i * 7 + 1));
         exp_rx.push_back(8'(i * 7 + 1));
      end
      start_burst(20, 0);
      for (int k = 0; k < 22; k++) begin
         repeat (15) @(negedge clk);
         rd(A_RXD, d);
         if (d != 0) got.push_back(d[7:0]);
      end
      wait_idle();
      for (int k = 0; k < 25; k++) begin
         rd(A_RXD, d);
         if (d != 0) got.push_back(d[7:0]);
      end
      chk("R11 byte total", 32'(got.size()), 20);
      for (int i = 0; i < 20 && i < got.size(); i++)
         chk($sformatf("R11 order %0d", i), 32'(got[i]), 32'(exp_rx[i]));

      // R7 transmit queue full drops pushes
      for (int i = 0; i < 70; i++) wr(A_TXD, 32'(i));
      rd(A_STAT, d); chk("R7 tx level capped", d, 32'h0000_4000);

      // R9 soft reset during a burst
      wr(A_CLK, 32'h1003);
      start_burst(10, 2);
      repeat (100) @(negedge clk);
      wr(A_CTRL, 32'h8000_0003);
      reg_addr = A_CTRL;
      #1 chk("R9 srst reads 1", reg_rdata, 32'h8000_0103);
      @(negedge clk);
      #1 chk("R9 srst self clears", reg_rdata, 32'h3);
      chk("R9 cs released", 32'(spi_cs_n), 1);
      rd(A_STAT, d); chk("R9 queues empty", d, 0);
      repeat (20) @(negedge clk);
      chk("R9 stays idle", 32'(spi_cs_n), 1);

      report();
   end

endmodule